// File: doc/BRIEF.md
# DRAM Channel Select Normalizer

This block sits after a node decoder in a memory controller's address path. The decoder has already matched a system address to a node. The block takes that address, the node's interleave width and the node's controller-select settings. It decides which of two DRAM controller channels owns the address. It removes the base or hoisting offset that applies to the address. It then squeezes out the address bits that were used for node and channel interleaving, which leaves a dense address local to the channel.

All decisions are combinational from one input beat. The channel number, the normalized channel address and a flag saying the high select range was taken are registered together with a valid bit. Chip-select matching downstream consumes these outputs. The search for the matching range happens upstream.

Top module: `chsel_norm`

## Requirements
- R1: `hi_range` is 1 only when `hi_rng_en` is 1, `gang_en` is 0 and `sys_addr` is at or above the select base, which is `sel_base_fld` shifted left by 27.
- R2: With `gang_en` = 1, `chan` equals `sys_addr[3]`, whatever the other controls are.
- R3: When not ganged, a high-range address takes `chan` = `hi_sel`. Failing that, interleave enabled with `ilv_mode` = 0 takes `chan` = `sys_addr[6]`.
- R4: When the above do not apply and interleave is enabled with `ilv_mode[1]` = 1, `chan` is the XOR parity of `sys_addr[20:16]` XORed with `sys_addr[9]` (mode 3) or with `sys_addr[6]` (mode 2).
- R5: When interleave is enabled with `ilv_mode` = 1, `chan` = `sys_addr[12 + node_ilog]`. With interleave off and `hi_rng_en` = 1, `chan` = NOT `hi_sel`. With both off, `chan` = 0.
- R6: In the high range, the subtracted offset is the hole offset (`hole_ofs_fld` << 23) when the select base is below the hole base (`hole_base_fld` << 24), `hole_valid` = 1 and `sys_addr` >= 2^32. Otherwise it is the select offset (`sel_ofs_fld` << 26).
- R7: Outside the high range, the subtracted offset is the hole offset when `hole_valid` = 1 and `sys_addr` >= 2^32. Otherwise it is `range_base`. Subtraction wraps modulo 2^48.
- R8: When `node_ilog` is nonzero, `node_ilog` bits starting at bit 12 are removed from the offset-corrected address. Bits [11:0] are kept and the upper bits move down.
- R9: When `ilv_en` = 1, `hi_range` = 0 and `gang_en` = 0, one more bit is removed after R8: bit 6 for modes 0 and 2, bit 12 for mode 1, and bit 9 for mode 3.
- R10: The outputs for a beat with `in_valid` = 1 appear one clock later with `out_valid` = 1. Reset clears `out_valid`, `chan`, `hi_range` and `chan_addr` to 0.
- R11: A cycle with `in_valid` = 0 drives `out_valid` to 0 and leaves `chan`, `hi_range` and `chan_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| sys_addr | input | 48 | Node-decoded system address |
| node_ilog | input | 2 | Log2 of node interleave count (0 = none) |
| range_base | input | 48 | Base address of the matched DRAM range |
| hole_valid | input | 1 | Memory hole hoisting active |
| hole_base_fld | input | 8 | Hole base, units of 2^24 |
| hole_ofs_fld | input | 9 | Hole hoist offset, units of 2^23 |
| gang_en | input | 1 | Both channels act as one wide channel |
| hi_rng_en | input | 1 | High select range enabled |
| hi_sel | input | 1 | Channel that owns the high range |
| ilv_en | input | 1 | Channel interleave enabled |
| ilv_mode | input | 2 | 0 bit 6, 1 bit 12+ilog, 2 hash on 6, 3 hash on 9 |
| sel_base_fld | input | 21 | High range start, units of 2^27 |
| sel_ofs_fld | input | 22 | High range offset, units of 2^26 |
| out_valid | output | 1 | Registered result valid |
| chan | output | 1 | Selected channel |
| hi_range | output | 1 | High select range taken |
| chan_addr | output | 48 | Normalized channel address |

## Verification
A wrong decision inside this block shows at the ports on the very next clock, because there is only one register stage. A bad priority order in the channel chain flips `chan` only for the combinations where two rules overlap. The bench therefore sweeps every setting of the gang, high-range, interleave, mode, node-log and hole controls, against addresses placed on both sides of the select base and of the 4 GB line. An offset or bit-removal fault shows as a `chan_addr` that differs from the arithmetic model, usually by a power of two. Hash faults show only when the parity of bits 20:16 is odd, so the addresses vary those bits.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

   // channel interleave modes, encoding is decoded bitwise by the router
   typedef enum logic [1:0] {
      ILV_BIT6  = 2'd0,
      ILV_BIT12 = 2'd1,
      ILV_HASH6 = 2'd2,
      ILV_HASH9 = 2'd3
   } ilv_mode_e;

   // which rule of the priority chain produced the channel
   typedef enum logic [2:0] {
      SRC_GANG,
      SRC_HIGH,
      SRC_LOW6,
      SRC_HASH,
      SRC_NODEBIT,
      SRC_INVHI,
      SRC_ZERO
   } chan_src_e;

   // which offset is removed from the address
   typedef enum logic [1:0] {
      OFS_HOLE,
      OFS_SELECT,
      OFS_RANGE
   } ofs_src_e;

endpackage

// File: rtl/chsel_route.sv
module chsel_route
   import chsel_pkg::*;
#(
   parameter int ADDR_W   = 48,
   parameter int ILOG_W   = 2,
   parameter int GANG_BIT = 3,
   parameter int HASH_LO  = 16,
   parameter int HASH_HI  = 20,
   parameter int BIT_A6   = 6,
   parameter int BIT_A9   = 9,
   parameter int BIT_A12  = 12,
   parameter int POS_W    = $clog2(ADDR_W)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] sel_base,
   input  logic [ILOG_W-1:0] node_ilog,
   input  logic              gang_en,
   input  logic              hi_rng_en,
   input  logic              hi_sel,
   input  logic              ilv_en,
   input  ilv_mode_e         ilv_mode,
   output logic              hi_range,
   output logic              chan,
   output logic              strip_en,
   output logic [POS_W-1:0]  strip_pos
);

   localparam int HASH_N = HASH_HI - HASH_LO + 1;

   chan_src_e         src;
   logic              hash_par;
   logic [HASH_N-1:0] hash_field;
   logic [ADDR_W-1:0] node_shift;

   assign hash_field = addr[HASH_HI:HASH_LO];
   assign hash_par   = ^hash_field;
   assign node_shift = addr >> (BIT_A12 + 32'(node_ilog));

   // the high range only exists with independent channels
   assign hi_range = hi_rng_en && !gang_en && (addr >= sel_base);

   // priority chain for the owning channel
   always_comb begin
      if (gang_en)
         src = SRC_GANG;
      else if (hi_range)
         src = SRC_HIGH;
      else if (ilv_en && ilv_mode == ILV_BIT6)
         src = SRC_LOW6;
      else if (ilv_en && ilv_mode[1])
         src = SRC_HASH;
      else if (ilv_en)
         src = SRC_NODEBIT;
      else if (hi_rng_en)
         src = SRC_INVHI;
      else
         src = SRC_ZERO;
   end

   always_comb begin
      unique case (src)
         SRC_GANG:    chan = addr[GANG_BIT];
         SRC_HIGH:    chan = hi_sel;
         SRC_LOW6:    chan = addr[BIT_A6];
         SRC_HASH:    chan = hash_par ^ (ilv_mode[0] ? addr[BIT_A9] : addr[BIT_A6]);
         SRC_NODEBIT: chan = node_shift[0];
         SRC_INVHI:   chan = !hi_sel;
         default:     chan = 1'b0;
      endcase
   end

   // channel-interleave bit removal follows the same gating
   assign strip_en = ilv_en && !hi_range && !gang_en;

   always_comb begin
      if (!ilv_mode[0])
         strip_pos = POS_W'(BIT_A6);
      else if (ilv_mode == ILV_BIT12)
         strip_pos = POS_W'(BIT_A12);
      else
         strip_pos = POS_W'(BIT_A9);
   end

endmodule

// File: rtl/chsel_offset.sv
module chsel_offset
   import chsel_pkg::*;
#(
   parameter int ADDR_W  = 48,
   parameter int LOW4G_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              hi_range,
   input  logic              hole_valid,
   input  logic [ADDR_W-1:0] hole_base,
   input  logic [ADDR_W-1:0] hole_ofs,
   input  logic [ADDR_W-1:0] sel_base,
   input  logic [ADDR_W-1:0] sel_ofs,
   input  logic [ADDR_W-1:0] range_base,
   output logic [ADDR_W-1:0] rebased
);

   ofs_src_e          pick;
   logic              above_4g;
   logic [ADDR_W-1:0] ofs;

   // any bit above the low 4 GB means the hoisted region
   assign above_4g = |addr[ADDR_W-1:LOW4G_W];

   always_comb begin
      if (hi_range)
         pick = (sel_base < hole_base && hole_valid && above_4g) ? OFS_HOLE : OFS_SELECT;
      else
         pick = (hole_valid && above_4g) ? OFS_HOLE : OFS_RANGE;
   end

   always_comb begin
      unique case (pick)
         OFS_HOLE:   ofs = hole_ofs;
         OFS_SELECT: ofs = sel_ofs;
         default:    ofs = range_base;
      endcase
   end

   assign rebased = addr - ofs;

endmodule

// File: rtl/chsel_strip.sv
module chsel_strip #(
   parameter int ADDR_W   = 48,
   parameter int ILOG_W   = 2,
   parameter int NODE_LSB = 12,
   parameter int POS_W    = $clog2(ADDR_W)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ILOG_W-1:0] node_ilog,
   input  logic              strip_en,
   input  logic [POS_W-1:0]  strip_pos,
   output logic [ADDR_W-1:0] squeezed
);

   localparam int NODE_OPTS = 1 << ILOG_W;

   // remove cnt bits starting at pos, close the gap
   function automatic logic [ADDR_W-1:0] drop_bits(
      input logic [ADDR_W-1:0] x,
      input int unsigned       pos,
      input int unsigned       cnt
   );
      logic [ADDR_W-1:0] keep;
      keep = ~({ADDR_W{1'b1}} << pos);
      return ((x >> (pos + cnt)) << pos) | (x & keep);
   endfunction

   logic [ADDR_W-1:0] node_opt [NODE_OPTS];
   logic [ADDR_W-1:0] after_node;

   // one fixed squeeze per possible node interleave width
   for (genvar g = 0; g < NODE_OPTS; g++) begin : g_node
      if (g == 0) begin : g_none
         assign node_opt[g] = addr;
      end else begin : g_drop
         assign node_opt[g] = drop_bits(addr, NODE_LSB, g);
      end
   end

   assign after_node = node_opt[node_ilog];

   assign squeezed = strip_en ? drop_bits(after_node, 32'(strip_pos), 1) : after_node;

endmodule

// File: rtl/chsel_norm.sv
module chsel_norm
   import chsel_pkg::*;
#(
   parameter int ADDR_W   = 48,
   parameter int ILOG_W   = 2,
   parameter int HOLEB_W  = 8,
   parameter int HOLEB_SH = 24,
   parameter int HOLEO_W  = 9,
   parameter int HOLEO_SH = 23,
   parameter int SELB_SH  = 27,
   parameter int SELO_SH  = 26,
   parameter int GANG_BIT = 3,
   parameter int HASH_LO  = 16,
   parameter int HASH_HI  = 20,
   parameter int NODE_LSB = 12
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [ADDR_W-1:0]         sys_addr,
   input  logic [ILOG_W-1:0]         node_ilog,
   input  logic [ADDR_W-1:0]         range_base,
   input  logic                      hole_valid,
   input  logic [HOLEB_W-1:0]        hole_base_fld,
   input  logic [HOLEO_W-1:0]        hole_ofs_fld,
   input  logic                      gang_en,
   input  logic                      hi_rng_en,
   input  logic                      hi_sel,
   input  logic                      ilv_en,
   input  logic [1:0]                ilv_mode,
   input  logic [ADDR_W-SELB_SH-1:0] sel_base_fld,
   input  logic [ADDR_W-SELO_SH-1:0] sel_ofs_fld,
   output logic                      out_valid,
   output logic                      chan,
   output logic                      hi_range,
   output logic [ADDR_W-1:0]         chan_addr
);

   localparam int POS_W   = $clog2(ADDR_W);
   localparam int HB_PAD  = ADDR_W - HOLEB_W - HOLEB_SH;
   localparam int HO_PAD  = ADDR_W - HOLEO_W - HOLEO_SH;
   localparam int LOW4G_W = 32;
   localparam int BIT_A6  = 6;
   localparam int BIT_A9  = 9;

   // elaboration-time sanity of the parameter set
   if (ADDR_W <= LOW4G_W + 2) begin : g_bad_aw
      $error("chsel_norm: ADDR_W too small");
   end
   if (HB_PAD < 0 || HO_PAD < 0) begin : g_bad_hole
      $error("chsel_norm: hole fields exceed ADDR_W");
   end
   if (HASH_HI >= ADDR_W || HASH_LO > HASH_HI) begin : g_bad_hash
      $error("chsel_norm: hash window invalid");
   end
   if (NODE_LSB + (1 << ILOG_W) >= ADDR_W) begin : g_bad_node
      $error("chsel_norm: node interleave window exceeds ADDR_W");
   end

   logic [ADDR_W-1:0] sel_base_w;
   logic [ADDR_W-1:0] sel_ofs_w;
   logic [ADDR_W-1:0] hole_base_w;
   logic [ADDR_W-1:0] hole_ofs_w;

   assign sel_base_w  = {sel_base_fld, {SELB_SH{1'b0}}};
   assign sel_ofs_w   = {sel_ofs_fld, {SELO_SH{1'b0}}};
   assign hole_base_w = {{HB_PAD{1'b0}}, hole_base_fld, {HOLEB_SH{1'b0}}};
   assign hole_ofs_w  = {{HO_PAD{1'b0}}, hole_ofs_fld, {HOLEO_SH{1'b0}}};

   logic              hi_c;
   logic              chan_c;
   logic              strip_en;
   logic [POS_W-1:0]  strip_pos;
   logic [ADDR_W-1:0] rebased;
   logic [ADDR_W-1:0] squeezed;

   chsel_route #(
      .ADDR_W  (ADDR_W),
      .ILOG_W  (ILOG_W),
      .GANG_BIT(GANG_BIT),
      .HASH_LO (HASH_LO),
      .HASH_HI (HASH_HI),
      .BIT_A6  (BIT_A6),
      .BIT_A9  (BIT_A9),
      .BIT_A12 (NODE_LSB),
      .POS_W   (POS_W)
   ) u_route (
      .addr     (sys_addr),
      .sel_base (sel_base_w),
      .node_ilog(node_ilog),
      .gang_en  (gang_en),
      .hi_rng_en(hi_rng_en),
      .hi_sel   (hi_sel),
      .ilv_en   (ilv_en),
      .ilv_mode (ilv_mode_e'(ilv_mode)),
      .hi_range (hi_c),
      .chan     (chan_c),
      .strip_en (strip_en),
      .strip_pos(strip_pos)
   );

   chsel_offset #(
      .ADDR_W (ADDR_W),
      .LOW4G_W(LOW4G_W)
   ) u_offset (
      .addr      (sys_addr),
      .hi_range  (hi_c),
      .hole_valid(hole_valid),
      .hole_base (hole_base_w),
      .hole_ofs  (hole_ofs_w),
      .sel_base  (sel_base_w),
      .sel_ofs   (sel_ofs_w),
      .range_base(range_base),
      .rebased   (rebased)
   );

   chsel_strip #(
      .ADDR_W  (ADDR_W),
      .ILOG_W  (ILOG_W),
      .NODE_LSB(NODE_LSB),
      .POS_W   (POS_W)
   ) u_strip (
      .addr     (rebased),
      .node_ilog(node_ilog),
      .strip_en (strip_en),
      .strip_pos(strip_pos),
      .squeezed (squeezed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         chan      <= 1'b0;
         hi_range  <= 1'b0;
         chan_addr <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            chan      <= chan_c;
            hi_range  <= hi_c;
            chan_addr <= squeezed;
         end
      end
   end

endmodule

// File: rtl/chsel_norm_chk.sv
module chsel_norm_chk #(
   parameter int ADDR_W  = 48,
   parameter int ILOG_W  = 2,
   parameter int SELB_SH = 27
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic [ADDR_W-1:0]         sys_addr,
   input logic [ILOG_W-1:0]         node_ilog,
   input logic [ADDR_W-1:0]         range_base,
   input logic                      hole_valid,
   input logic                      gang_en,
   input logic                      hi_rng_en,
   input logic                      hi_sel,
   input logic                      ilv_en,
   input logic [ADDR_W-SELB_SH-1:0] sel_base_fld,
   input logic                      out_valid,
   input logic                      chan,
   input logic                      hi_range,
   input logic [ADDR_W-1:0]         chan_addr
);

   // R1: high range needs the enable, independent channels and a high address
   a_r1_hi_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && hi_range) |-> ($past(hi_rng_en) && !$past(gang_en) &&
                                   ($past(sys_addr) >= {$past(sel_base_fld), {SELB_SH{1'b0}}})));

   // R2: ganged mode takes the channel from address bit 3
   a_r2_gang_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(gang_en)) |-> (chan == $past(sys_addr[3])));

   // R3: the high range owner is the high-select bit
   a_r3_hi_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && hi_range) |-> (chan == $past(hi_sel)));

   // R7: with every transform off, the address only loses the range base
   a_r7_plain_rebase: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(!hole_valid && !hi_rng_en && !gang_en && !ilv_en && node_ilog == '0))
      |-> (chan_addr == $past(sys_addr) - $past(range_base)));

   // R10: an accepted beat yields a valid result one clock later
   a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R11: results stay put through idle cycles
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(chan_addr) && $stable(chan) && $stable(hi_range)));

endmodule

bind chsel_norm chsel_norm_chk #(
   .ADDR_W (ADDR_W),
   .ILOG_W (ILOG_W),
   .SELB_SH(SELB_SH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .sys_addr    (sys_addr),
   .node_ilog   (node_ilog),
   .range_base  (range_base),
   .hole_valid  (hole_valid),
   .gang_en     (gang_en),
   .hi_rng_en   (hi_rng_en),
   .hi_sel      (hi_sel),
   .ilv_en      (ilv_en),
   .sel_base_fld(sel_base_fld),
   .out_valid   (out_valid),
   .chan        (chan),
   .hi_range    (hi_range),
   .chan_addr   (chan_addr)
);

// File: tb/chsel_norm_test.sv
`timescale 1ns/1ps
module chsel_norm_test;

   localparam int AW = 48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [AW-1:0] sys_addr = '0;
   logic [1:0]    node_ilog = '0;
   logic [AW-1:0] range_base = '0;
   logic          hole_valid = 1'b0;
   logic [7:0]    hole_base_fld = 8'hC0;
   logic [8:0]    hole_ofs_fld = 9'h1A0;
   logic          gang_en = 1'b0;
   logic          hi_rng_en = 1'b0;
   logic          hi_sel = 1'b0;
   logic          ilv_en = 1'b0;
   logic [1:0]    ilv_mode = '0;
   logic [20:0]   sel_base_fld = '0;
   logic [21:0]   sel_ofs_fld = '0;
   logic          out_valid;
   logic          chan;
   logic          hi_range;
   logic [AW-1:0] chan_addr;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   always #5 clk = ~clk;

   chsel_norm uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sys_addr(sys_addr),
      .node_ilog(node_ilog), .range_base(range_base), .hole_valid(hole_valid),
      .hole_base_fld(hole_base_fld), .hole_ofs_fld(hole_ofs_fld),
      .gang_en(gang_en), .hi_rng_en(hi_rng_en), .hi_sel(hi_sel), .ilv_en(ilv_en),
      .ilv_mode(ilv_mode), .sel_base_fld(sel_base_fld), .sel_ofs_fld(sel_ofs_fld),
      .out_valid(out_valid), .chan(chan), .hi_range(hi_range), .chan_addr(chan_addr)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] next_rand();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 7);
      rng = rng ^ (rng << 17);
      return rng;
   endfunction

   // remove cnt bits at pos arithmetically
   function automatic logic [AW-1:0] cut(input logic [AW-1:0] x, input int pos, input int cnt);
      logic [AW-1:0] lo_div;
      logic [AW-1:0] hi_div;
      lo_div = 48'd1 << pos;
      hi_div = 48'd1 << (pos + cnt);
      return (x / hi_div) * lo_div + (x % lo_div);
   endfunction

   function automatic void model(input logic [AW-1:0] a, output logic ch, output logic hi,
                                 output logic [AW-1:0] ca, output string ctag, output string atag);
      logic [AW-1:0] sb, so, hb, ho, ofs;
      logic big;
      int ones;
      sb = 48'(sel_base_fld) * 48'h800_0000;
      so = 48'(sel_ofs_fld) * 48'h400_0000;
      hb = 48'(hole_base_fld) * 48'h100_0000;
      ho = 48'(hole_ofs_fld) * 48'h80_0000;
      big = (a >= 48'h1_0000_0000);
      hi = hi_rng_en && !gang_en && (a >= sb);
      ones = 0;
      for (int i = 16; i <= 20; i++) ones += int'(a[i]);
      if (gang_en) begin ch = a[3]; ctag = "R2"; end
      else if (hi) begin ch = hi_sel; ctag = "R3"; end
      else if (ilv_en && ilv_mode == 2'd0) begin ch = a[6]; ctag = "R3"; end
      else if (ilv_en && ilv_mode == 2'd3) begin ch = a[9] ^ (ones % 2 == 1); ctag = "R4"; end
      else if (ilv_en && ilv_mode == 2'd2) begin ch = a[6] ^ (ones % 2 == 1); ctag = "R4"; end
      else if (ilv_en) begin ch = a[12 + int'(node_ilog)]; ctag = "R5"; end
      else if (hi_rng_en) begin ch = !hi_sel; ctag = "R5"; end
      else begin ch = 1'b0; ctag = "R5"; end
      if (hi) begin
         ofs = (sb < hb && hole_valid && big) ? ho : so;
         atag = "R6";
      end else begin
         ofs = (hole_valid && big) ? ho : range_base;
         atag = "R7";
      end
      ca = a - ofs;
      if (node_ilog != 0) begin
         ca = cut(ca, 12, int'(node_ilog));
         atag = {atag, " R8"};
      end
      if (ilv_en && !hi && !gang_en) begin
         if (ilv_mode == 2'd1) ca = cut(ca, 12, 1);
         else if (ilv_mode == 2'd3) ca = cut(ca, 9, 1);
         else ca = cut(ca, 6, 1);
         atag = {atag, " R9"};
      end
   endfunction

   task automatic apply_and_check(input logic [AW-1:0] a);
      logic ech, ehi;
      logic [AW-1:0] eca;
      string ctag, atag;
      @(negedge clk);
      in_valid = 1'b1;
      sys_addr = a;
      model(a, ech, ehi, eca, ctag, atag);
      @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b1, "R10", "out_valid", 64'(out_valid), 64'd1);
      check(chan == ech, ctag, "chan", 64'(chan), 64'(ech));
      check(hi_range == ehi, "R1", "hi_range", 64'(hi_range), 64'(ehi));
      check(chan_addr == eca, atag, "chan_addr", 64'(chan_addr), 64'(eca));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] held;
      logic [AW-1:0] sb;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: reset state
      check(out_valid == 1'b0, "R10", "reset out_valid", 64'(out_valid), 64'd0);
      check(chan == 1'b0, "R10", "reset chan", 64'(chan), 64'd0);
      check(hi_range == 1'b0, "R10", "reset hi_range", 64'(hi_range), 64'd0);
      check(chan_addr == '0, "R10", "reset chan_addr", 64'(chan_addr), 64'd0);
      rst_n = 1'b1;

      // sweep every control combination
      for (int c = 0; c < 512; c++) begin
         @(negedge clk);
         gang_en      = c[0];
         hi_rng_en    = c[1];
         hi_sel       = c[2];
         ilv_en       = c[3];
         ilv_mode     = 2'(c >> 4);
         node_ilog    = 2'(c >> 6);
         hole_valid   = c[8];
         sel_base_fld = (c[4] ^ c[6]) ? 21'h30 : 21'h3;
         sel_ofs_fld  = 22'(5 + (c % 16));
         range_base   = 48'(c % 16) << 24;
         sb = 48'(sel_base_fld) << 27;
         apply_and_check(48'(next_rand()) & 48'hF_FFFF_FFFF);
         apply_and_check(48'(next_rand()) & 48'hFFFF_FFFF);
         apply_and_check(sb - 48'd1);
         apply_and_check(sb);
         apply_and_check(48'hFFFF_FFFF);
         apply_and_check(48'h1_0000_0000);
         apply_and_check((48'(next_rand()) & 48'hFF_FFE0_FFFF) | (48'(c % 32) << 16));
         apply_and_check(48'(next_rand()) & 48'hFF_FFFF_FFFF);
      end

      // R11: idle cycle keeps the outputs
      held = chan_addr;
      @(negedge clk);
      in_valid = 1'b0;
      sys_addr = ~sys_addr;
      @(posedge clk);
      @(negedge clk);
      check(out_valid == 1'b0, "R11", "idle out_valid", 64'(out_valid), 64'd0);
      check(chan_addr == held, "R11", "idle chan_addr", 64'(chan_addr), 64'(held));

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule